// File: doc/BRIEF.md
# DMA Channel Status and Control Register Block

This block holds the software-visible state of a single DMA channel. It lives in a 64-byte register window, and each channel has its own window at the next 0x40 boundary. Software starts, pauses, continues and aborts the channel through a control byte. It reads sticky completion and error flags from a status byte and a five-bit cause code from an error byte. It also programs two interrupt vector numbers, one for normal completion and one for errors.

A separate transfer sequencer reports events to the block: operation complete, block complete, device termination, DONE-input transition and error with a cause code. The block turns these into sticky status bits, an interrupt request and the vector number to present with it. It also watches a peripheral control line (PCL). The line goes through a synchronizer, and its level and falling edges are recorded. A new start is refused while any flag that blocks a start is set. A refused start is recorded as an operation timing error.

Top module: `dma_chan_regs`

## Requirements
- R1: After a synchronous active-low reset, the status byte reads 0x01 (PCL idle high, every other bit 0). The error byte, the control byte and both vector bytes read 0x00, and chan_active, chan_start and irq_req are 0.
- R2: The window offsets are 0x00 status, 0x01 error code (read-only), 0x02 control, 0x03 normal vector and 0x04 error vector. Both vectors read back what was written. Every other offset reads 0x00 and ignores writes.
- R3: The status byte layout, from bit 7 down to bit 0, is: complete, block done, device termination, error, active, DONE-input transition, PCL transition and PCL level.
- R4: Status bits 7, 6, 5, 4, 2 and 1 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A hardware set in the same cycle as a software clear wins.
- R5: A control write with bit 7 (start) set while status bits 7..3 are all 0 sets active. chan_start is then high for exactly one cycle.
- R6: A start attempted while any of status bits 7..3 is 1 does not start the channel. Instead it sets the error bit with code 00010.
- R7: A control write with bit 4 (abort) set clears active and sets the error bit with code 10001. Abort wins over a start bit in the same write.
- R8: A sequencer op-done sets complete and clears active. A sequencer error sets the error bit, loads its code and clears active. Block-done, device-termination and DONE-input events set bits 6, 5 and 2.
- R9: The error code loads only while the error bit is 0, so the first cause is kept. Clearing the error bit returns the code to 00000.
- R10: The PCL level bit follows pcl_in two clocks after it changes. The PCL transition bit sets on a falling edge of pcl_in only, never on a rising edge.
- R11: irq_req is 1 exactly when the interrupt enable (control bit 3) is 1 and either complete or error is set.
- R12: irq_vector is the error vector while the error bit is 1, and the normal vector otherwise.
- R13: Control bits 6 (continue), 5 (halt) and 3 (interrupt enable) are stored, read back and drive chan_continue and chan_halt. Start and abort read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset within the channel window |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pcl_in | input | 1 | Peripheral control line, asynchronous |
| seq_op_done | input | 1 | Sequencer: operation complete |
| seq_blk_done | input | 1 | Sequencer: block complete |
| seq_dev_term | input | 1 | Sequencer: device termination |
| seq_done_in | input | 1 | Sequencer: DONE input seen |
| seq_err | input | 1 | Sequencer: error event |
| seq_err_code | input | 5 | Cause code for seq_err |
| chan_active | output | 1 | Channel active flag |
| chan_start | output | 1 | One-cycle start pulse to the sequencer |
| chan_continue | output | 1 | Continue mode level |
| chan_halt | output | 1 | Halt request level |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 8 | Vector number for the current interrupt |

## Verification
The bench targets a restart while a completion flag is still pending. A design that ignored the blocking flags would raise chan_start there, and one that refused silently would leave the error byte at zero. It writes start and abort together to catch a design that lets the start win, and it raises a second error over a pending one to catch a code that is overwritten instead of keeping the first cause. It also sets and clears the same bit in one cycle, drives PCL rising edges to catch transition logic that fires on both edges, and clears the error bit to check that the vector and request fall back.

// File: rtl/dma_chan_pkg.sv
// Package: shared offsets, status bit positions and error codes for the
// DMA channel register block. Assumes an 8-bit register data path.
package dma_chan_pkg;

    localparam int WIN_ADDR_W = 6;
    localparam int CODE_W     = 5;

    // Register offsets inside a channel window
    localparam logic [WIN_ADDR_W-1:0] OFF_STAT = 6'h00;
    localparam logic [WIN_ADDR_W-1:0] OFF_ERR  = 6'h01;
    localparam logic [WIN_ADDR_W-1:0] OFF_CTRL = 6'h02;
    localparam logic [WIN_ADDR_W-1:0] OFF_NVEC = 6'h03;
    localparam logic [WIN_ADDR_W-1:0] OFF_EVEC = 6'h04;

    // Status byte bit positions
    localparam int SB_COMPLETE = 7;
    localparam int SB_BLOCK    = 6;
    localparam int SB_DEVTERM  = 5;
    localparam int SB_ERROR    = 4;
    localparam int SB_ACTIVE   = 3;
    localparam int SB_DONEIN   = 2;
    localparam int SB_PCLEDGE  = 1;
    localparam int SB_PCLLVL   = 0;

    // Control byte bit positions
    localparam int CB_START = 7;
    localparam int CB_CONT  = 6;
    localparam int CB_HALT  = 5;
    localparam int CB_ABORT = 4;
    localparam int CB_IE    = 3;

    // Error cause codes
    localparam logic [CODE_W-1:0] EC_NONE    = 5'b00000;
    localparam logic [CODE_W-1:0] EC_TIMING  = 5'b00010;
    localparam logic [CODE_W-1:0] EC_SW_STOP = 5'b10001;

    // Sticky-flag set/clear vector: index order of the six sticky bits
    typedef struct packed {
        logic complete;
        logic block;
        logic devterm;
        logic error;
        logic donein;
        logic pcledge;
    } sticky_t;

endpackage

// File: rtl/dcr_pcl_sync.sv
// Module: dcr_pcl_sync
// Brings the asynchronous peripheral control line into the clock domain
// through STAGES flops and flags falling edges of the synchronized level.
// Assumes the line idles high; the chain resets to 1 so that reset release
// creates no false edge.
module dcr_pcl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pcl_async,
    output logic pcl_level,
    output logic pcl_fall
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Synchronizer chain; stage 0 samples the raw pin
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= pcl_async;
                end
            end else begin : g_next
                // Shift toward the output
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    // Previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign pcl_level = chain_q[STAGES-1];
    assign pcl_fall  = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/dcr_ctrl.sv
// Module: dcr_ctrl
// Holds the control byte level bits (continue, halt, interrupt enable) and
// the two vector bytes, and decodes start and abort write pulses.
// Assumes write strobes are already decoded by offset.
module dcr_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_nvec,
    input  logic              wr_evec,
    input  logic [DATA_W-1:0] wdata,
    output logic              start_req,
    output logic              abort_req,
    output logic              cont_q,
    output logic              halt_q,
    output logic              ie_q,
    output logic [DATA_W-1:0] nvec_q,
    output logic [DATA_W-1:0] evec_q,
    output logic [DATA_W-1:0] ctrl_byte
);
    import dma_chan_pkg::*;

    // Stored control levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_q <= 1'b0;
            halt_q <= 1'b0;
            ie_q   <= 1'b0;
        end else if (wr_ctrl) begin
            cont_q <= wdata[CB_CONT];
            halt_q <= wdata[CB_HALT];
            ie_q   <= wdata[CB_IE];
        end
    end

    // Normal-completion vector register
    always_ff @(posedge clk) begin
        if (!rst_n)       nvec_q <= '0;
        else if (wr_nvec) nvec_q <= wdata;
    end

    // Error vector register
    always_ff @(posedge clk) begin
        if (!rst_n)       evec_q <= '0;
        else if (wr_evec) evec_q <= wdata;
    end

    // Action pulses and readback image
    always_comb begin
        start_req = wr_ctrl & wdata[CB_START];
        abort_req = wr_ctrl & wdata[CB_ABORT];
        ctrl_byte = '0;
        ctrl_byte[CB_CONT] = cont_q;
        ctrl_byte[CB_HALT] = halt_q;
        ctrl_byte[CB_IE]   = ie_q;
    end

endmodule

// File: rtl/dcr_status.sv
// Module: dcr_status
// Keeps the sticky status flags, the active flag and the error cause code.
// Decides whether a start is accepted or turned into a timing error.
// Assumes a hardware set beats a software clear in the same cycle, and
// records only the first error cause until the error bit is cleared.
module dcr_status #(
    parameter int CODE_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  dma_chan_pkg::sticky_t clr,
    input  logic                  ev_op_done,
    input  logic                  ev_blk_done,
    input  logic                  ev_dev_term,
    input  logic                  ev_done_in,
    input  logic                  ev_err,
    input  logic [CODE_W-1:0]     ev_err_code,
    input  logic                  pcl_level,
    input  logic                  pcl_fall,
    input  logic                  start_req,
    input  logic                  abort_req,
    output logic [7:0]            stat_byte,
    output logic [CODE_W-1:0]     err_code,
    output logic                  active_q,
    output logic                  start_pulse
);
    import dma_chan_pkg::*;

    sticky_t           flag_q, flag_d, set_v;
    logic              blocked;
    logic              start_ok;
    logic              timing_err;
    logic              err_free;
    logic [CODE_W-1:0] code_d;

    // Start gating and error source selection
    always_comb begin
        blocked    = flag_q.complete | flag_q.block | flag_q.devterm
                   | flag_q.error | active_q;
        start_ok   = start_req & ~abort_req & ~blocked;
        timing_err = start_req & ~abort_req & blocked;

        set_v.complete = ev_op_done;
        set_v.block    = ev_blk_done;
        set_v.devterm  = ev_dev_term;
        set_v.error    = ev_err | timing_err | abort_req;
        set_v.donein   = ev_done_in;
        set_v.pcledge  = pcl_fall;

        flag_d = (flag_q & ~clr) | set_v;

        err_free = ~flag_q.error | clr.error;
        code_d   = err_code;
        if (err_free) begin
            if (abort_req)       code_d = EC_SW_STOP;
            else if (ev_err)     code_d = ev_err_code;
            else if (timing_err) code_d = EC_TIMING;
            else if (clr.error)  code_d = EC_NONE;
        end
    end

    // Sticky flags register
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    // Error cause register
    always_ff @(posedge clk) begin
        if (!rst_n) err_code <= EC_NONE;
        else        err_code <= code_d;
    end

    // Active flag: set on accepted start, cleared on any ending event
    always_ff @(posedge clk) begin
        if (!rst_n)                             active_q <= 1'b0;
        else if (start_ok)                      active_q <= 1'b1;
        else if (ev_op_done | ev_err | abort_req) active_q <= 1'b0;
    end

    // One-cycle start pulse toward the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) start_pulse <= 1'b0;
        else        start_pulse <= start_ok;
    end

    // Status byte image
    always_comb begin
        stat_byte              = '0;
        stat_byte[SB_COMPLETE] = flag_q.complete;
        stat_byte[SB_BLOCK]    = flag_q.block;
        stat_byte[SB_DEVTERM]  = flag_q.devterm;
        stat_byte[SB_ERROR]    = flag_q.error;
        stat_byte[SB_ACTIVE]   = active_q;
        stat_byte[SB_DONEIN]   = flag_q.donein;
        stat_byte[SB_PCLEDGE]  = flag_q.pcledge;
        stat_byte[SB_PCLLVL]   = pcl_level;
    end

endmodule

// File: rtl/dcr_irq.sv
// Module: dcr_irq
// Forms the interrupt request from the enable and the complete/error flags
// and selects the vector number. Purely combinational.
module dcr_irq #(
    parameter int DATA_W = 8
) (
    input  logic              ie,
    input  logic              complete,
    input  logic              error,
    input  logic [DATA_W-1:0] nvec,
    input  logic [DATA_W-1:0] evec,
    output logic              irq,
    output logic [DATA_W-1:0] vector
);

    // Request and vector choice
    always_comb begin
        irq    = ie & (complete | error);
        vector = error ? evec : nvec;
    end

endmodule

// File: rtl/dma_chan_regs.sv
// Module: dma_chan_regs
// Register and status logic of one DMA channel in a 64-byte window.
// Decodes register writes, routes sequencer events and the PCL input into
// the status logic, and presents the interrupt request and vector.
// Assumes reads are combinational and side-effect free.
module dma_chan_regs #(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 8,
    parameter int CODE_W     = 5,
    parameter int PCL_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pcl_in,
    input  logic              seq_op_done,
    input  logic              seq_blk_done,
    input  logic              seq_dev_term,
    input  logic              seq_done_in,
    input  logic              seq_err,
    input  logic [CODE_W-1:0] seq_err_code,
    output logic              chan_active,
    output logic              chan_start,
    output logic              chan_continue,
    output logic              chan_halt,
    output logic              irq_req,
    output logic [DATA_W-1:0] irq_vector
);
    import dma_chan_pkg::*;

    localparam int PAD_W = DATA_W - CODE_W;

    logic              wr_stat, wr_ctrl, wr_nvec, wr_evec;
    sticky_t           clr_v;
    logic              pcl_level, pcl_fall;
    logic              start_req, abort_req;
    logic              ie_q;
    logic [DATA_W-1:0] nvec_q, evec_q, ctrl_byte, stat_byte;
    logic [CODE_W-1:0] err_code;

    // Write strobe decode and clear mask
    always_comb begin
        wr_stat = reg_we && (reg_addr == ADDR_W'(OFF_STAT));
        wr_ctrl = reg_we && (reg_addr == ADDR_W'(OFF_CTRL));
        wr_nvec = reg_we && (reg_addr == ADDR_W'(OFF_NVEC));
        wr_evec = reg_we && (reg_addr == ADDR_W'(OFF_EVEC));
        clr_v   = '0;
        if (wr_stat) begin
            clr_v.complete = reg_wdata[SB_COMPLETE];
            clr_v.block    = reg_wdata[SB_BLOCK];
            clr_v.devterm  = reg_wdata[SB_DEVTERM];
            clr_v.error    = reg_wdata[SB_ERROR];
            clr_v.donein   = reg_wdata[SB_DONEIN];
            clr_v.pcledge  = reg_wdata[SB_PCLEDGE];
        end
    end

    dcr_pcl_sync #(.STAGES(PCL_STAGES)) pcl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pcl_async (pcl_in),
        .pcl_level (pcl_level),
        .pcl_fall  (pcl_fall)
    );

    dcr_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_nvec   (wr_nvec),
        .wr_evec   (wr_evec),
        .wdata     (reg_wdata),
        .start_req (start_req),
        .abort_req (abort_req),
        .cont_q    (chan_continue),
        .halt_q    (chan_halt),
        .ie_q      (ie_q),
        .nvec_q    (nvec_q),
        .evec_q    (evec_q),
        .ctrl_byte (ctrl_byte)
    );

    dcr_status #(.CODE_W(CODE_W)) stat_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr_v),
        .ev_op_done  (seq_op_done),
        .ev_blk_done (seq_blk_done),
        .ev_dev_term (seq_dev_term),
        .ev_done_in  (seq_done_in),
        .ev_err      (seq_err),
        .ev_err_code (seq_err_code),
        .pcl_level   (pcl_level),
        .pcl_fall    (pcl_fall),
        .start_req   (start_req),
        .abort_req   (abort_req),
        .stat_byte   (stat_byte),
        .err_code    (err_code),
        .active_q    (chan_active),
        .start_pulse (chan_start)
    );

    dcr_irq #(.DATA_W(DATA_W)) irq_i (
        .ie       (ie_q),
        .complete (stat_byte[SB_COMPLETE]),
        .error    (stat_byte[SB_ERROR]),
        .nvec     (nvec_q),
        .evec     (evec_q),
        .irq      (irq_req),
        .vector   (irq_vector)
    );

    // Read data mux; unmapped offsets return zero
    always_comb begin
        unique case (reg_addr)
            ADDR_W'(OFF_STAT): reg_rdata = stat_byte;
            ADDR_W'(OFF_ERR):  reg_rdata = {{PAD_W{1'b0}}, err_code};
            ADDR_W'(OFF_CTRL): reg_rdata = ctrl_byte;
            ADDR_W'(OFF_NVEC): reg_rdata = nvec_q;
            ADDR_W'(OFF_EVEC): reg_rdata = evec_q;
            default:           reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_chan_regs_chk.sv
// Module: dma_chan_regs_chk
// Assertion checker bound to dma_chan_regs. Observes the write port, the
// outputs and the internal status byte, error code and vectors.
module dma_chan_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [5:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] stat_byte,
    input logic [4:0] err_code,
    input logic [7:0] evec_q,
    input logic       ie_q,
    input logic       chan_active,
    input logic       chan_start,
    input logic       irq_req,
    input logic [7:0] irq_vector
);
    logic wr_c, wr_s;
    assign wr_c = reg_we && (reg_addr == 6'h02);
    assign wr_s = reg_we && (reg_addr == 6'h00);

    // R5
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && reg_wdata[7] && !reg_wdata[4] && stat_byte[7:3] == 5'b0)
        |=> (chan_active && chan_start));

    // R6
    blocked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && reg_wdata[7] && stat_byte[7:3] != 5'b0)
        |=> (!chan_start && stat_byte[4]));

    // R7
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && reg_wdata[4]) |=> (!chan_active && !chan_start && stat_byte[4]));

    // R4
    sticky_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_byte[7] && !(wr_s && reg_wdata[7])) |=> stat_byte[7]);

    // R9
    first_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_byte[4] && !(wr_s && reg_wdata[4])) |=> $stable(err_code));

    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (ie_q && (stat_byte[7] || stat_byte[4])));

    // R12
    err_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_byte[4] |-> (irq_vector == evec_q));

endmodule

bind dma_chan_regs dma_chan_regs_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .stat_byte   (stat_byte),
    .err_code    (err_code),
    .evec_q      (evec_q),
    .ie_q        (ie_q),
    .chan_active (chan_active),
    .chan_start  (chan_start),
    .irq_req     (irq_req),
    .irq_vector  (irq_vector)
);

// File: tb/dma_chan_regs_tb.sv
// Directed bench for dma_chan_regs: one task per scenario.
module dma_chan_regs_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       pcl_in = 1'b1;
    logic       seq_op_done = 1'b0, seq_blk_done = 1'b0, seq_dev_term = 1'b0;
    logic       seq_done_in = 1'b0, seq_err = 1'b0;
    logic [4:0] seq_err_code = '0;
    logic       chan_active, chan_start, chan_continue, chan_halt, irq_req;
    logic [7:0] irq_vector;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pcl_in(pcl_in),
        .seq_op_done(seq_op_done), .seq_blk_done(seq_blk_done),
        .seq_dev_term(seq_dev_term), .seq_done_in(seq_done_in),
        .seq_err(seq_err), .seq_err_code(seq_err_code),
        .chan_active(chan_active), .chan_start(chan_start),
        .chan_continue(chan_continue), .chan_halt(chan_halt),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Read a register combinationally in the current (post-edge) cycle
    task automatic rd_chk(input string tag, input logic [5:0] a, input int exp);
        reg_addr = a;
        #1;
        check(tag, int'(reg_rdata), exp);
    endtask

    // One-cycle write; returns at the negedge after the capturing edge
    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    // One-cycle sequencer event: {op, blk, dev, donein, err}
    task automatic ev(input logic [4:0] m, input logic [4:0] code);
        @(negedge clk);
        {seq_op_done, seq_blk_done, seq_dev_term, seq_done_in, seq_err} = m;
        seq_err_code = code;
        @(negedge clk);
        {seq_op_done, seq_blk_done, seq_dev_term, seq_done_in, seq_err} = '0;
        seq_err_code = '0;
    endtask

    task automatic t_reset;
        rd_chk("R1 status", 6'h00, 8'h01);
        rd_chk("R1 errcode", 6'h01, 8'h00);
        rd_chk("R1 ctrl", 6'h02, 8'h00);
        rd_chk("R1 nvec", 6'h03, 8'h00);
        check("R1 active/start/irq", {chan_active, chan_start, irq_req}, 0);
    endtask

    task automatic t_map;
        wr(6'h03, 8'h40);
        wr(6'h04, 8'h41);
        wr(6'h10, 8'hFF);
        rd_chk("R2 nvec", 6'h03, 8'h40);
        rd_chk("R2 evec", 6'h04, 8'h41);
        rd_chk("R2 unmapped", 6'h10, 8'h00);
        rd_chk("R2 status untouched", 6'h00, 8'h01);
    endtask

    task automatic t_ctrl_readback;
        wr(6'h02, 8'h68);
        rd_chk("R13 ctrl readback", 6'h02, 8'h68);
        check("R13 cont/halt", {chan_continue, chan_halt}, 3);
        wr(6'h02, 8'h00);
        check("R13 cont/halt off", {chan_continue, chan_halt}, 0);
    endtask

    task automatic t_irq_disabled;
        ev(5'b10000, 5'd0);
        check("R11 irq disabled", irq_req, 0);
        rd_chk("R8 complete set", 6'h00, 8'h81);
        wr(6'h00, 8'h80);
        rd_chk("R4 clear complete", 6'h00, 8'h01);
    endtask

    task automatic t_start_done;
        wr(6'h02, 8'h88);
        check("R5 start pulse", chan_start, 1);
        check("R5 active", chan_active, 1);
        rd_chk("R3 status active bit", 6'h00, 8'h09);
        rd_chk("R13 start reads 0", 6'h02, 8'h08);
        @(negedge clk);
        check("R5 pulse one cycle", chan_start, 0);
        ev(5'b10000, 5'd0);
        check("R8 active cleared", chan_active, 0);
        rd_chk("R8 complete", 6'h00, 8'h81);
        check("R11 irq on complete", irq_req, 1);
        check("R12 normal vector", irq_vector, 8'h40);
    endtask

    task automatic t_blocked;
        wr(6'h02, 8'h88);
        check("R6 no start pulse", chan_start, 0);
        check("R6 not active", chan_active, 0);
        rd_chk("R6 status", 6'h00, 8'h91);
        rd_chk("R6 timing code", 6'h01, 8'h02);
        check("R12 error vector", irq_vector, 8'h41);
        wr(6'h00, 8'h00);
        rd_chk("R4 write zero no effect", 6'h00, 8'h91);
        wr(6'h00, 8'h90);
        rd_chk("R4 w1c both", 6'h00, 8'h01);
        rd_chk("R9 code cleared", 6'h01, 8'h00);
        check("R11 irq drops", irq_req, 0);
        check("R12 vector back to normal", irq_vector, 8'h40);
    endtask

    task automatic t_abort;
        wr(6'h02, 8'h88);
        check("R5 restart", chan_active, 1);
        wr(6'h02, 8'h18);
        check("R7 abort clears active", chan_active, 0);
        rd_chk("R7 status", 6'h00, 8'h11);
        rd_chk("R7 sw stop code", 6'h01, 8'h11);
        wr(6'h00, 8'h10);
        wr(6'h02, 8'h98);
        check("R7 abort beats start", {chan_start, chan_active}, 0);
        rd_chk("R7 code on combined", 6'h01, 8'h11);
        wr(6'h00, 8'h10);
    endtask

    task automatic t_first_cause;
        wr(6'h02, 8'h88);
        ev(5'b00001, 5'b00101);
        check("R8 err clears active", chan_active, 0);
        rd_chk("R8 err code loaded", 6'h01, 8'h05);
        wr(6'h02, 8'h88);
        rd_chk("R9 first cause kept", 6'h01, 8'h05);
        ev(5'b00001, 5'b10000);
        rd_chk("R9 first cause kept 2", 6'h01, 8'h05);
        wr(6'h00, 8'h10);
        rd_chk("R9 cleared", 6'h01, 8'h00);
    endtask

    task automatic t_set_wins;
        ev(5'b10000, 5'd0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'h00; reg_wdata = 8'h80; seq_op_done = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0; seq_op_done = 1'b0;
        rd_chk("R4 set beats clear", 6'h00, 8'h81);
        wr(6'h00, 8'h80);
    endtask

    task automatic t_other_events;
        ev(5'b01110, 5'd0);
        rd_chk("R8 blk/dev/donein", 6'h00, 8'h65);
        check("R11 no irq for others", irq_req, 0);
        wr(6'h00, 8'h64);
        rd_chk("R4 clear others", 6'h00, 8'h01);
    endtask

    task automatic t_pcl;
        @(negedge clk); pcl_in = 1'b0;
        @(negedge clk);
        rd_chk("R10 level not yet", 6'h00, 8'h01);
        repeat (3) @(negedge clk);
        rd_chk("R10 fall", 6'h00, 8'h02);
        wr(6'h00, 8'h02);
        rd_chk("R10 edge cleared", 6'h00, 8'h00);
        @(negedge clk); pcl_in = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk("R10 rise no edge", 6'h00, 8'h01);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_ctrl_readback();
        t_irq_disabled();
        t_start_done();
        t_blocked();
        t_abort();
        t_first_cause();
        t_set_wins();
        t_other_events();
        t_pcl();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule